// File: doc/BRIEF.md
# SEC-DED Protected Word Memory

This block sits between a 32-bit processor memory port and an internal word array. Every stored word carries 7 check bits from an extended Hamming code, so 39 bits are kept per address. On a read the block recomputes the check bits, corrects any single flipped bit and flags two flipped bits as uncorrectable. Only the 32 data bits go back to the requester.

Requests use a valid/ready handshake. A request moves on the edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the requester has to hold its request stable until then. A full write (all four byte enables set) finishes in the cycle it is accepted and gives no response. A partial write runs as a read-modify-write: the block reads and corrects the stored word, merges in the enabled bytes, recomputes the check bits and writes the word back. This costs one extra cycle, during which `req_ready` is low. A read returns its data on a response channel with `rsp_valid` and `rsp_ready`. The block holds the response until it is accepted and takes no new request while a response is pending.

Each detected error is written into a small log memory separate from the data array, through a wrapping pointer, and a saturating error counter counts the events. A corrected error gives a one-cycle interrupt request pulse. An uncorrectable error gives a one-cycle reset request pulse. A force-error input corrupts the word being written, so that both error paths can be exercised.

Top module: `secded_mem_wrap`

## Requirements
- R1: A read accepted on rising edge k raises `rsp_valid` after edge k+2, with `rsp_valid` low between those edges. A full write followed by a read of the same address returns the written word.
- R2: The check word is 6 Hamming position parities plus 1 overall parity. Data bit i sits at the (i+1)-th position in 1..38 that is not a power of two, so data bit 0 is at position 3 and data bit 1 is at position 5. A word written with no injection reads back with no interrupt and no reset request.
- R3: In a partial write, the bytes whose `req_be` bit is set (bit b covers data bits 8b+7..8b) take the new data. The other bytes keep the corrected stored value.
- R4: After accepting a write with any byte enable clear, `req_ready` is low for exactly one cycle. After accepting a full write, `req_ready` stays high.
- R5: Injection code 01 flips stored data bit 0. A read of that word returns the written data and gives `irq_single` for exactly one cycle, coinciding with the first `rsp_valid` cycle. Code 11 behaves like 00 and injects nothing.
- R6: Injection code 10 flips stored data bits 0 and 1. A read of that word gives `rst_req` for one cycle with `rsp_valid`, no `irq_single`, and returns the stored data uncorrected (bits 0 and 1 inverted).
- R7: Each error event writes a log entry laid out as bits [6:0] syndrome {odd overall parity, 6-bit position}, bit 7 the uncorrectable flag, and bits [ADDR_W+7:8] the word address. A flip of bit 0 logs syndrome 0x43; a flip of bits 0 and 1 logs 0x06.
- R8: Log entries are written at a pointer that starts at 0 and wraps after LOG_DEPTH entries, so event LOG_DEPTH+1 overwrites entry 0.
- R9: `err_count` goes up by one for each error event and saturates at its maximum.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values and `req_ready` stays low.
- R11: After reset, `req_ready` is 1 and `rsp_valid`, `irq_single`, `rst_req` and `err_count` are 0.
- R12: A partial write to a word with a single-bit error raises `irq_single` for one cycle after the extra cycle and logs the event. The word written back is clean, so the next read gives no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| force_err | input | 2 | Injection code applied to the word being written |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Requester accepts read data |
| rsp_rdata | output | 32 | Corrected read data |
| irq_single | output | 1 | One-cycle pulse on a corrected error |
| rst_req | output | 1 | One-cycle pulse on an uncorrectable error |
| log_raddr | input | clog2(LOG_DEPTH) | Error-log entry select |
| log_rdata | output | ADDR_W+8 | Selected error-log entry |
| err_count | output | CNT_W | Saturating count of error events |

## Verification
A wrong parity position map or a wrong syndrome decode shows in the first response of an injected read. It appears as wrong data, as a swapped interrupt or reset pulse, or as a logged syndrome other than 0x43 or 0x06, two edges after the read is accepted. A merge or sequencing fault shows as wrong bytes in the next read of a partially written address, or as `req_ready` that is not low in the cycle after the partial write is accepted. A pointer or counter fault shows in the log contents and `err_count` right after the pulse of the event concerned.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW    = 32;
  localparam int PW    = 6;
  localparam int CW    = PW + 1;
  localparam int NPOS  = DW + PW;
  localparam int SYN_W = CW;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE, ST_RESP} wrap_state_e;

  function automatic logic is_data_pos(input int pos);
    return (pos & (pos - 1)) != 0;
  endfunction

  // Position parities over data bits placed at non-power-of-two positions.
  function automatic logic [PW-1:0] pos_parity(input logic [DW-1:0] d);
    logic [PW-1:0] p;
    int idx;
    p   = '0;
    idx = 0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if (is_data_pos(pos)) begin
        for (int k = 0; k < PW; k++) begin
          if (pos[k]) p[k] = p[k] ^ d[idx];
        end
        idx++;
      end
    end
    return p;
  endfunction

  // Invert the data bit sitting at Hamming position syn (if it is a data position).
  function automatic logic [DW-1:0] fix_bit(input logic [DW-1:0] d, input logic [PW-1:0] syn);
    logic [DW-1:0] r;
    int idx;
    r   = d;
    idx = 0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if (is_data_pos(pos)) begin
        if (syn == pos[PW-1:0]) r[idx] = ~r[idx];
        idx++;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] inj_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 32'h0000_0001;
      2'b10:   return 32'h0000_0003;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DW-1:0] data_in,
  output logic [CW-1:0] check_out
);
  logic [PW-1:0] ppar;

  always_comb begin
    ppar      = pos_parity(data_in);
    check_out = {ppar, (^data_in) ^ (^ppar)};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [DW+CW-1:0] code_in,
  output logic [DW-1:0]    data_out,
  output logic [SYN_W-1:0] syndrome,
  output logic             err_single,
  output logic             err_double
);
  logic [DW-1:0] raw;
  logic [CW-1:0] chk;
  logic [PW-1:0] syn;
  logic          odd;
  logic          beyond;

  always_comb begin
    raw    = code_in[DW+CW-1:CW];
    chk    = code_in[CW-1:0];
    syn    = pos_parity(raw) ^ chk[CW-1:1];
    odd    = (^raw) ^ (^chk);
    beyond = syn > PW'(NPOS);
    err_single = odd && !beyond;
    err_double = (!odd && (syn != '0)) || (odd && beyond);
    syndrome   = {odd, syn};
    data_out   = err_single ? fix_bit(raw, syn) : raw;
  end
endmodule

// File: rtl/secded_err_log.sv
module secded_err_log
  import secded_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LOG_DEPTH = 4,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_single,
  input  logic                         ev_double,
  input  logic [ADDR_W-1:0]            ev_addr,
  input  logic [SYN_W-1:0]             ev_syn,
  input  logic [$clog2(LOG_DEPTH)-1:0] rd_addr,
  output logic [ADDR_W+SYN_W:0]        rd_entry,
  output logic [CNT_W-1:0]             err_count
);
  localparam int LOG_AW = $clog2(LOG_DEPTH);
  localparam int ENT_W  = ADDR_W + SYN_W + 1;
  localparam logic [LOG_AW-1:0] LAST = LOG_AW'(LOG_DEPTH - 1);

  logic [ENT_W-1:0]  entries [LOG_DEPTH];
  logic [LOG_AW-1:0] wptr;
  logic [CNT_W-1:0]  cnt;
  logic              ev;

  assign ev = ev_single | ev_double;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < LOG_DEPTH; i++) entries[i] <= '0;
    end else if (ev) begin
      entries[wptr] <= {ev_addr, ev_double, ev_syn};
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  assign rd_entry  = entries[rd_addr];
  assign err_count = cnt;

  // R7
  entry_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> entries[$past(wptr)] == {$past(ev_addr), $past(ev_double), $past(ev_syn)});
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(wptr));
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && cnt != '1) |=> cnt == $past(cnt) + 1'b1);
  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(cnt));
endmodule

// File: rtl/secded_mem_wrap.sv
module secded_mem_wrap
  import secded_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LOG_DEPTH = 4,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  input  logic [3:0]                   req_be,
  input  logic [1:0]                   force_err,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [31:0]                  rsp_rdata,
  output logic                         irq_single,
  output logic                         rst_req,
  input  logic [$clog2(LOG_DEPTH)-1:0] log_raddr,
  output logic [ADDR_W+SYN_W:0]        log_rdata,
  output logic [CNT_W-1:0]             err_count
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BYTES = DW / 8;
  localparam int WW    = DW + CW;

  wrap_state_e       state;
  logic [WW-1:0]     mem [DEPTH];
  logic [WW-1:0]     rd_word;
  logic [ADDR_W-1:0] op_addr;
  logic [DW-1:0]     op_wdata;
  logic [BYTES-1:0]  op_be;
  logic [1:0]        op_force;
  logic [DW-1:0]     rsp_q;
  logic              irq_q, rst_q;

  logic              accept, full_be, full_wr;
  logic [DW-1:0]     dec_data, merged, enc_data;
  logic [CW-1:0]     enc_check;
  logic [SYN_W-1:0]  dec_syn;
  logic              dec_single, dec_double, dec_live;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [1:0]        wr_force;

  assign accept  = req_valid && req_ready;
  assign full_be = &req_be;
  assign full_wr = accept && req_write && full_be;

  secded_dec u_dec (
    .code_in    (rd_word),
    .data_out   (dec_data),
    .syndrome   (dec_syn),
    .err_single (dec_single),
    .err_double (dec_double)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = op_be[b] ? op_wdata[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign enc_data  = (state == ST_MERGE) ? merged : req_wdata;
  assign mem_waddr = (state == ST_MERGE) ? op_addr : req_addr;
  assign wr_force  = (state == ST_MERGE) ? op_force : force_err;
  assign mem_we    = full_wr || (state == ST_MERGE);
  assign dec_live  = (state == ST_READ) || (state == ST_MERGE);

  secded_enc u_enc (
    .data_in   (enc_data),
    .check_out (enc_check)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= {enc_data ^ inj_mask(wr_force), enc_check};
    if (accept && !full_wr) rd_word <= mem[req_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_addr  <= '0;
      op_wdata <= '0;
      op_be    <= '0;
      op_force <= '0;
      rsp_q    <= '0;
      irq_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      irq_q <= dec_live && dec_single;
      rst_q <= dec_live && dec_double;
      case (state)
        ST_IDLE: begin
          if (accept && !full_wr) begin
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            op_be    <= req_be;
            op_force <= force_err;
            state    <= req_write ? ST_MERGE : ST_READ;
          end
        end
        ST_READ: begin
          rsp_q <= dec_data;
          state <= ST_RESP;
        end
        ST_MERGE: state <= ST_IDLE;
        ST_RESP:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_rdata  = rsp_q;
  assign irq_single = irq_q;
  assign rst_req    = rst_q;

  secded_err_log #(
    .ADDR_W    (ADDR_W),
    .LOG_DEPTH (LOG_DEPTH),
    .CNT_W     (CNT_W)
  ) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_single (dec_live && dec_single),
    .ev_double (dec_live && dec_double),
    .ev_addr   (op_addr),
    .ev_syn    (dec_syn),
    .rd_addr   (log_raddr),
    .rd_entry  (log_rdata),
    .err_count (err_count)
  );

  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !rsp_valid ##1 rsp_valid);
  // R4
  rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !full_be) |=> !req_ready ##1 req_ready);
  // R4
  full_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr |=> req_ready);
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_single |=> !irq_single);
  // R6
  sev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_single && rst_req));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && !req_ready);
endmodule

// File: tb/secded_mem_wrap_tb.sv
module secded_mem_wrap_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int LOG_DEPTH  = 4;
  localparam int CNT_W      = 8;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [1:0]  force_err = '0;
  logic [1:0]  log_raddr = '0;
  logic req_ready, rsp_valid, irq_single, rst_req;
  logic [31:0] rsp_rdata;
  logic [ADDR_W+7:0] log_rdata;
  logic [CNT_W-1:0]  err_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_mem  [DEPTH];
  int          exp_kind [DEPTH];
  logic [ADDR_W+7:0] exp_log [LOG_DEPTH];
  int exp_wptr = 0;
  int exp_cnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_mem_wrap #(.ADDR_W(ADDR_W), .LOG_DEPTH(LOG_DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .force_err(force_err), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_single(irq_single), .rst_req(rst_req),
    .log_raddr(log_raddr), .log_rdata(log_rdata), .err_count(err_count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [1:0] f);
    return (f == 2'b01) ? 1 : (f == 2'b10) ? 2 : 0;
  endfunction

  function automatic logic [31:0] stored_data(input int a);
    return (exp_kind[a] == 2) ? (exp_mem[a] ^ 32'h3) : exp_mem[a];
  endfunction

  function automatic logic [31:0] merge_be(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // R7 R8 R9: model one error event and check the newest log entry and count
  task automatic note_event(input int a, input int k);
    logic [ADDR_W+7:0] e;
    e = {a[ADDR_W-1:0], (k == 2), (k == 1) ? 7'h43 : 7'h06};
    exp_log[exp_wptr] = e;
    log_raddr = exp_wptr[1:0];
    exp_wptr = (exp_wptr + 1) % LOG_DEPTH;
    if (exp_cnt < 255) exp_cnt++;
    #1;
    chk("R7 log entry", log_rdata, e);
    chk("R9 err_count", err_count, exp_cnt);
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be,
                          input logic [1:0] f);
    int k_old;
    logic [31:0] m;
    k_old = exp_kind[a];
    m = merge_be(stored_data(a), d, be);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a[ADDR_W-1:0];
    req_wdata = d; req_be = be; force_err = f;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; force_err = 2'b00;
    if (be == 4'hF) begin
      chk("R4 ready after full write", req_ready, 1);
      exp_mem[a] = d;
    end else begin
      chk("R4 ready low in merge cycle", req_ready, 0);
      @(negedge clk);
      chk("R4 ready back after merge", req_ready, 1);
      chk("R12 irq on merge of single error", irq_single, k_old == 1);
      chk("R6 reset req on merge of double error", rst_req, k_old == 2);
      if (k_old != 0) note_event(a, k_old);
      exp_mem[a] = m;
    end
    exp_kind[a] = kind_of(f);
  endtask

  task automatic do_read(input int a, input int hold);
    int k;
    logic [31:0] ed;
    k  = exp_kind[a];
    ed = stored_data(a);
    if (k == 1) ed = exp_mem[a];
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a[ADDR_W-1:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R1 no response one edge after accept", rsp_valid, 0);
    @(negedge clk);
    chk("R1 response two edges after accept", rsp_valid, 1);
    chk(k == 0 ? "R2 clean read data" : k == 1 ? "R5 corrected data" : "R6 uncorrected data",
        rsp_rdata, ed);
    chk("R5 irq with first response cycle", irq_single, k == 1);
    chk("R6 reset req with first response cycle", rst_req, k == 2);
    if (k != 0) note_event(a, k);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 valid held", rsp_valid, 1);
      chk("R10 data held", rsp_rdata, ed);
      chk("R10 no request while pending", req_ready, 0);
      chk("R5 irq single cycle", irq_single, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R10 response released", rsp_valid, 0);
  endtask

  task automatic check_log_all();
    for (int i = 0; i < LOG_DEPTH; i++) begin
      log_raddr = i[1:0];
      #1;
      chk("R8 log entry after wrap", log_rdata, exp_log[i]);
    end
    chk("R9 final err_count", err_count, exp_cnt);
  endtask

  initial begin
    for (int i = 0; i < LOG_DEPTH; i++) exp_log[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin exp_mem[i] = '0; exp_kind[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset req_ready", req_ready, 1);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R11 reset irq", irq_single, 0);
    chk("R11 reset rst_req", rst_req, 0);
    chk("R11 reset err_count", err_count, 0);

    for (int i = 0; i < DEPTH; i++) do_write(i, 32'hA5A5_0000 + i, 4'hF, 2'b00);
    do_write(1, 32'hDEAD_BEEF, 4'hF, 2'b00);
    do_read(1, 0);                                   // R1 R2
    do_write(1, 32'h1122_3344, 4'b0101, 2'b00);      // R3
    chk("R3 merge model", exp_mem[1], 32'hDE22_BE44);
    do_read(1, 0);
    do_write(2, 32'h0F0F_1234, 4'hF, 2'b01);         // R5
    do_read(2, 0);
    do_read(2, 0);                                   // no scrubbing
    do_write(3, 32'h8000_0001, 4'hF, 2'b10);         // R6
    do_read(3, 0);
    do_write(2, 32'h0000_5500, 4'b0010, 2'b00);      // R12
    do_read(2, 0);
    do_write(4, 32'h1357_9BDF, 4'hF, 2'b11);         // R5 code 11 injects nothing
    do_read(4, 3);                                   // R10
    do_read(3, 0);                                   // fifth event wraps to entry 0
    log_raddr = 2'd0;
    #1;
    chk("R8 entry 0 overwritten", log_rdata, {4'd3, 1'b1, 7'h06});
    check_log_all();

    void'($urandom(32'd2718));
    for (int n = 0; n < 300; n++) begin
      int a, sel;
      logic [1:0] f;
      a = $urandom % DEPTH;
      sel = $urandom % 8;
      f = (sel == 0) ? 2'b01 : (sel == 1) ? 2'b10 : 2'b00;
      if ($urandom % 2 == 0) begin
        logic [3:0] be;
        be = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
        do_write(a, $urandom, be, f);
      end else begin
        do_read(a, $urandom % 4);
      end
    end
    check_log_all();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule